// File: doc/BRIEF.md
# Counter Snapshot Read Path

This block sits between an array of wide event counters and a narrow processor data bus. Each counter is twice as wide as the bus, so a full value takes two byte reads. The first byte read of a counter copies the whole counter into a single shared holding register. The matching read of the other byte is then served from that copy, so both halves describe the same moment even if the live counter moved in between. The bytes may be fetched in either order.

Read requests enter on a valid/ready channel and carry three fields: a counter-space flag, a counter index and a byte select. Read data leaves on a single-entry valid/ready response channel. A request is accepted only when the response slot is empty or is being drained in the same cycle (`rsp_ready` high). It is also held off while the counter array reports an update in progress, so a snapshot never catches a counter partway through a count. While `rsp_valid` is high and `rsp_ready` is low, the response data stays frozen and no new request is accepted.

Whenever a fresh snapshot is loaded, a one-cycle strobe is raised on the bit of the captured counter. Counters that clear on read use this strobe to reset.

Top module: `cnt_snap_reader`

## Requirements
- R1: After reset `rsp_valid` and every `snap_stb` bit are low, `req_ready` is high, and no snapshot is held, so the first counter read always loads fresh.
- R2: An accepted counter read that is not the second half of an open pair copies the addressed live counter into the holding register. In the next cycle the requested byte of that live value appears on `rsp_data`, and `snap_stb[idx]` is high for that one cycle.
- R3: Byte select encoding: `req_hi`=0 selects bits [7:0] and `req_hi`=1 selects bits [15:8]. A read of the other byte of the counter held in an open pair returns that byte from the holding register rather than the live counter, raises no `snap_stb` bit, and closes the pair.
- R4: The pair works with either order, lower byte first or upper byte first.
- R5: A request with `req_cnt`=0 is a non-counter read. It returns zero data, raises no `snap_stb` bit, and leaves any open pair intact.
- R6: A read of a different counter while a pair is open reloads the holding register from that counter, discards the unread byte, and raises the new counter's strobe.
- R7: A repeated read of the same byte of the held counter reloads the holding register from the live counter and raises its strobe again.
- R8: Once a pair is complete, the next read of that counter takes a fresh snapshot of the live value.
- R9: `req_ready` is low whenever `cnt_upd` is high, so no request is accepted during a counter update.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` stays stable, `rsp_valid` stays high and `req_ready` is low.
- R11: At most one `snap_stb` bit is high in any cycle, and a strobe only appears alongside a valid response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_cnt | input | 1 | 1: request addresses the counter space |
| req_idx | input | IDX_W (3) | Counter index |
| req_hi | input | 1 | Byte select, 1 = upper byte |
| cnt_upd | input | 1 | Counter array updating this cycle |
| cnt_vals | input | NUM_CNT*CNT_W (128) | Live counter values, counter i at bits [i*CNT_W +: CNT_W] |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes read data |
| rsp_data | output | BUS_W (8) | Read data byte |
| snap_stb | output | NUM_CNT (8) | One-cycle pulse per counter on snapshot load |

## Verification
Directed sequences change the live counter between the two byte reads, so a byte served from the holding register can be told apart from a byte taken from the live value. Lower-first and upper-first pairs separate order handling. Interleaved non-counter reads, reads of another counter and repeated same-byte reads separate the cases that keep the pair open from those that reload it. Stalls from `cnt_upd` and from a held-off consumer show that acceptance and response data respect both kinds of back-pressure.

// File: rtl/snap_pkg.sv
package snap_pkg;
  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_e;
endpackage

// File: rtl/cnt_snap_mux.sv
module cnt_snap_mux #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 16,
  parameter int IDX_W   = 3
) (
  input  logic [NUM_CNT*CNT_W-1:0] vals,
  input  logic [IDX_W-1:0]         idx,
  output logic [CNT_W-1:0]         val
);
  logic [CNT_W-1:0] lane [NUM_CNT];

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_lane
    assign lane[g] = vals[g*CNT_W +: CNT_W];
  end

  always_comb begin
    val = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (idx == IDX_W'(i)) val = lane[i];
    end
  end
endmodule

// File: rtl/cnt_snap_ctrl.sv
module cnt_snap_ctrl
  import snap_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc,
  input  logic             acc_cnt,
  input  logic [IDX_W-1:0] acc_idx,
  input  logic             acc_hi,
  input  logic [CNT_W-1:0] live_val,
  output logic             use_hold,
  output logic             take_snap,
  output logic [CNT_W-1:0] hold_val
);
  logic             pair_open;
  logic [IDX_W-1:0] pair_idx;
  half_e            pair_served;
  logic             pair_hit;

  // Second half of an open pair: same counter, opposite byte.
  assign pair_hit  = pair_open && (pair_idx == acc_idx) &&
                     (half_e'(acc_hi) != pair_served);
  assign use_hold  = acc && acc_cnt && pair_hit;
  assign take_snap = acc && acc_cnt && !pair_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_open   <= 1'b0;
      pair_idx    <= '0;
      pair_served <= HALF_LO;
      hold_val    <= '0;
    end else if (take_snap) begin
      pair_open   <= 1'b1;
      pair_idx    <= acc_idx;
      pair_served <= half_e'(acc_hi);
      hold_val    <= live_val;
    end else if (use_hold) begin
      pair_open   <= 1'b0;
    end
  end
endmodule

// File: rtl/cnt_snap_resp.sv
module cnt_snap_resp #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 16,
  parameter int BUS_W   = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc,
  input  logic               acc_cnt,
  input  logic [IDX_W-1:0]   acc_idx,
  input  logic               acc_hi,
  input  logic               use_hold,
  input  logic               take_snap,
  input  logic [CNT_W-1:0]   live_val,
  input  logic [CNT_W-1:0]   hold_val,
  input  logic               rsp_ready,
  output logic               rsp_valid,
  output logic [BUS_W-1:0]   rsp_data,
  output logic [NUM_CNT-1:0] snap_stb
);
  logic [CNT_W-1:0] src;
  logic [BUS_W-1:0] byte_n;
  logic [BUS_W-1:0] data_n;

  assign src    = use_hold ? hold_val : live_val;
  assign byte_n = acc_hi ? src[CNT_W-1 -: BUS_W] : src[BUS_W-1:0];
  assign data_n = acc_cnt ? byte_n : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc) begin
      rsp_valid <= 1'b1;
      rsp_data  <= data_n;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_stb
    always_ff @(posedge clk) begin
      if (!rst_n) snap_stb[g] <= 1'b0;
      else        snap_stb[g] <= take_snap && (acc_idx == IDX_W'(g));
    end
  end
endmodule

// File: rtl/cnt_snap_reader.sv
module cnt_snap_reader #(
  parameter int NUM_CNT = 8,
  parameter int BUS_W   = 8,
  localparam int CNT_W  = 2 * BUS_W,
  localparam int IDX_W  = (NUM_CNT > 1) ? $clog2(NUM_CNT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_cnt,
  input  logic [IDX_W-1:0]         req_idx,
  input  logic                     req_hi,
  input  logic                     cnt_upd,
  input  logic [NUM_CNT*CNT_W-1:0] cnt_vals,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [BUS_W-1:0]         rsp_data,
  output logic [NUM_CNT-1:0]       snap_stb
);
  logic             acc;
  logic [CNT_W-1:0] live_val;
  logic [CNT_W-1:0] hold_val;
  logic             use_hold;
  logic             take_snap;

  assign req_ready = !cnt_upd && (!rsp_valid || rsp_ready);
  assign acc       = req_valid && req_ready;

  cnt_snap_mux #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .IDX_W(IDX_W)) mux_i (
    .vals (cnt_vals),
    .idx  (req_idx),
    .val  (live_val)
  );

  cnt_snap_ctrl #(.CNT_W(CNT_W), .IDX_W(IDX_W)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .acc_cnt   (req_cnt),
    .acc_idx   (req_idx),
    .acc_hi    (req_hi),
    .live_val  (live_val),
    .use_hold  (use_hold),
    .take_snap (take_snap),
    .hold_val  (hold_val)
  );

  cnt_snap_resp #(.NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .BUS_W(BUS_W), .IDX_W(IDX_W)) resp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc       (acc),
    .acc_cnt   (req_cnt),
    .acc_idx   (req_idx),
    .acc_hi    (req_hi),
    .use_hold  (use_hold),
    .take_snap (take_snap),
    .live_val  (live_val),
    .hold_val  (hold_val),
    .rsp_ready (rsp_ready),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .snap_stb  (snap_stb)
  );
endmodule

// File: rtl/cnt_snap_reader_chk.sv
module cnt_snap_reader_chk #(
  parameter int NUM_CNT = 8,
  parameter int BUS_W   = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_cnt,
  input logic [IDX_W-1:0]   req_idx,
  input logic               cnt_upd,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [BUS_W-1:0]   rsp_data,
  input logic [NUM_CNT-1:0] snap_stb
);
  a_r9_no_accept_in_update: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_upd |-> !req_ready);

  a_r10_rsp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  a_r10_no_accept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  a_r11_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(snap_stb));

  a_r11_strobe_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    (|snap_stb) |-> rsp_valid);

  a_r2_strobe_hits_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (|snap_stb) |-> $past(req_valid && req_ready && req_cnt));

  a_r5_noncnt_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_cnt) |=> (rsp_data == '0 && snap_stb == '0));

  a_r1_rsp_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(req_valid && req_ready));

  // Index value kept for trace visibility alongside strobes.
  logic unused_idx;
  assign unused_idx = ^req_idx;
endmodule

bind cnt_snap_reader cnt_snap_reader_chk #(
  .NUM_CNT(NUM_CNT), .BUS_W(BUS_W), .IDX_W(IDX_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_cnt   (req_cnt),
  .req_idx   (req_idx),
  .cnt_upd   (cnt_upd),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .snap_stb  (snap_stb)
);

// File: tb/cnt_snap_reader_tb_top.sv
module cnt_snap_reader_tb_top;
  localparam int N = 8;
  localparam int BW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_cnt = 1'b1;
  logic [2:0]    req_idx = '0;
  logic          req_hi = 1'b0;
  logic          cnt_upd = 1'b0;
  logic [N*CW-1:0] cnt_vals = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [BW-1:0] rsp_data;
  logic [N-1:0]  snap_stb;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  cnt_snap_reader #(.NUM_CNT(N), .BUS_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cnt(req_cnt), .req_idx(req_idx), .req_hi(req_hi), .cnt_upd(cnt_upd),
    .cnt_vals(cnt_vals), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .snap_stb(snap_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_cnt(input int i, input logic [15:0] v);
    cnt_vals[i*CW +: CW] = v;
  endtask

  // One read through the handshake; returns data and strobe of the response cycle.
  task automatic rd(input logic c, input int i, input logic hi,
                    output logic [7:0] d, output logic [N-1:0] s);
    @(negedge clk);
    req_valid = 1'b1; req_cnt = c; req_idx = 3'(i); req_hi = hi;
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    d = rsp_data; s = snap_stb;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd_chk(input logic c, input int i, input logic hi,
                        input logic [7:0] ed, input logic [N-1:0] es, input string req);
    logic [7:0] d;
    logic [N-1:0] s;
    rd(c, i, hi, d, s);
    chk(d == ed, {req, " data"}, d, ed);
    chk(s == es, {req, " strobe"}, s, es);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
    chk(snap_stb == '0, "R1 snap_stb", snap_stb, 0);
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
  endtask

  task automatic t_lo_first;  // R2 R3
    set_cnt(3, 16'hA1B2);
    rd_chk(1, 3, 0, 8'hB2, 8'b0000_1000, "R2 lo live");
    set_cnt(3, 16'hC3D4);
    rd_chk(1, 3, 1, 8'hA1, 8'h00, "R3 hi held");
  endtask

  task automatic t_hi_first;  // R4
    set_cnt(5, 16'h1234);
    rd_chk(1, 5, 1, 8'h12, 8'b0010_0000, "R4 hi first");
    set_cnt(5, 16'h5678);
    rd_chk(1, 5, 0, 8'h34, 8'h00, "R4 lo held");
  endtask

  task automatic t_noncnt;  // R5
    set_cnt(2, 16'hABCD);
    rd_chk(1, 2, 0, 8'hCD, 8'b0000_0100, "R5 open pair");
    set_cnt(2, 16'h0000);
    rd_chk(0, 6, 1, 8'h00, 8'h00, "R5 noncounter");
    rd_chk(1, 2, 1, 8'hAB, 8'h00, "R5 pair intact");
  endtask

  task automatic t_other_cnt;  // R6
    set_cnt(1, 16'h1111);
    set_cnt(6, 16'h6677);
    rd_chk(1, 1, 0, 8'h11, 8'b0000_0010, "R6 first");
    rd_chk(1, 6, 1, 8'h66, 8'b0100_0000, "R6 other counter");
    set_cnt(1, 16'h2222);
    rd_chk(1, 1, 1, 8'h22, 8'b0000_0010, "R6 discarded byte");
  endtask

  task automatic t_same_byte;  // R7
    set_cnt(4, 16'h4455);
    rd_chk(1, 4, 0, 8'h55, 8'b0001_0000, "R7 first");
    set_cnt(4, 16'h8899);
    rd_chk(1, 4, 0, 8'h99, 8'b0001_0000, "R7 same byte reload");
    set_cnt(4, 16'hFFFF);
    rd_chk(1, 4, 1, 8'h88, 8'h00, "R7 pair from reload");
  endtask

  task automatic t_after_pair;  // R8
    set_cnt(0, 16'h0102);
    rd_chk(1, 0, 0, 8'h02, 8'b0000_0001, "R8 lo");
    rd_chk(1, 0, 1, 8'h01, 8'h00, "R8 hi");
    set_cnt(0, 16'h0304);
    rd_chk(1, 0, 1, 8'h03, 8'b0000_0001, "R8 fresh after pair");
  endtask

  task automatic t_upd_stall;  // R9
    set_cnt(7, 16'h9A9B);
    @(negedge clk);
    cnt_upd = 1'b1; req_valid = 1'b1; req_cnt = 1'b1; req_idx = 3'd7; req_hi = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(req_ready == 1'b0, "R9 ready low in update", req_ready, 0);
      chk(rsp_valid == 1'b0, "R9 no response in update", rsp_valid, 0);
    end
    cnt_upd = 1'b0;
    @(posedge clk); #1;
    chk(rsp_valid && rsp_data == 8'h9B, "R9 accepted after update", rsp_data, 8'h9B);
    @(negedge clk);
    req_valid = 1'b0;
    rd_chk(1, 7, 1, 8'h9A, 8'h00, "R9 pair close");
  endtask

  task automatic t_backpressure;  // R10 R11
    set_cnt(7, 16'h7E7F);
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_cnt = 1'b1; req_idx = 3'd7; req_hi = 1'b0;
    @(posedge clk); #1;
    chk(rsp_data == 8'h7F, "R10 first byte", rsp_data, 8'h7F);
    chk(snap_stb == 8'b1000_0000, "R11 strobe one bit", snap_stb, 8'h80);
    @(negedge clk);
    req_hi = 1'b1;
    set_cnt(7, 16'h0000);
    for (int k = 0; k < 2; k++) begin
      chk(req_ready == 1'b0, "R10 ready low while held", req_ready, 0);
      chk(rsp_valid && rsp_data == 8'h7F, "R10 data held", rsp_data, 8'h7F);
      @(negedge clk);
    end
    chk(snap_stb == '0, "R11 strobe one cycle", snap_stb, 0);
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    chk(rsp_valid && rsp_data == 8'h7E, "R10 drain and accept", rsp_data, 8'h7E);
    chk(snap_stb == '0, "R10 held byte no strobe", snap_stb, 0);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 drained", rsp_valid, 0);
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_lo_first();
    t_hi_first();
    t_noncnt();
    t_other_cnt();
    t_same_byte();
    t_after_pair();
    t_upd_stall();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule